// File: doc/BRIEF.md
# Overwriting Page Write Buffer

This block sits between the byte-level receiver of a two-wire serial memory and its 256 x 8 storage array. A write transaction is opened by a start strobe, which also carries the starting word address. Data bytes then arrive one per byte-valid strobe, and their number is set by the bus master alone. The buffer can hold sixteen bytes. When more arrive, each new byte pushes out the byte that has been held longest, so the buffer always holds the sixteen most recent bytes.

Nothing reaches the array until the stop strobe. At that point the held bytes are written one at a time, oldest first, to consecutive addresses starting at the latched address. The address wraps inside the 16-byte page that contains it. Each byte occupies a fixed, parameterised number of clocks of internal programming time, and a busy flag is raised for that time. A protection block outside this one can veto the commit: if its veto input is high on the stop strobe, the pending bytes are discarded.

Top module: `page_wbuf`

## Requirements
- R1: While busy is high, a start strobe is ignored. No transaction opens, and any bytes or stop that follow cause no array write.
- R2: A transaction of N bytes, with N from 1 to 16, writes exactly N bytes, and the byte values are written in arrival order.
- R3: When more than 16 bytes arrive, only the last 16 are written. The earliest bytes are discarded in the order they arrived.
- R4: No array write strobe occurs while a transaction is open. Writes begin only after the stop strobe.
- R5: A second start strobe before a stop discards every pending byte and latches the new start address.
- R6: The k-th committed byte (k = 0 upward, oldest first) goes to address {start_addr[7:4], (start_addr[3:0] + k) mod 16}.
- R7: Busy rises on the clock edge that registers the stop strobe. It stays high for exactly N x PROG_CYC clocks. arr_we pulses for one clock at the first clock of each byte's slot.
- R8: If veto is high in the stop cycle, no write occurs and busy stays low.
- R9: A stop strobe with no bytes received causes no write and leaves busy low.
- R10: A byte-valid strobe outside an open transaction is ignored.
- R11: After reset, busy and arr_we are low.
- R12: Within an open transaction, start has priority over stop, and stop has priority over byte-valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_start | input | 1 | Start-condition strobe; opens or restarts a transaction |
| txn_stop | input | 1 | Stop-condition strobe; ends the transaction and requests a commit |
| byte_vld | input | 1 | A received data byte is present on byte_data |
| byte_data | input | 8 | Received data byte |
| start_addr | input | 8 | Starting word address, sampled with txn_start |
| veto | input | 1 | Protection veto, sampled with txn_stop |
| busy | output | 1 | Internal programming cycle in progress |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | 8 | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The hardest state to reach from the ports is a full buffer whose write pointer has moved partway around, so that the oldest byte is not in slot zero. The commit must then begin mid-buffer and wrap both the buffer index and the in-page address. The bench reaches this state by sending twenty bytes to an address in the middle of a page. It then checks that the write log begins with the fifth byte, at the start address, and steps through the page wrap. A second hard case is a start strobe that lands while a commit is still draining. The bench issues it, together with bytes and a stop, in the cycles just after a short commit begins.

// File: rtl/page_wbuf_pkg.sv
package page_wbuf_pkg;
    typedef enum logic [0:0] {
        MODE_IDLE = 1'b0,
        MODE_OPEN = 1'b1
    } wb_mode_e;
endpackage

// File: rtl/pgb_ring.sv
// Sixteen-deep overwriting store: keeps the newest DEPTH bytes of a stream.
module pgb_ring #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count,
    output logic [IW-1:0] oldest
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [IW-1:0]            wp;
        logic [CW-1:0]            cnt;
    } ring_t;

    ring_t ring_d, ring_q;
    logic  full;

    assign full = (ring_q.cnt == CW'(DEPTH));

    always_comb begin
        ring_d = ring_q;
        if (clr) begin
            ring_d.wp  = '0;
            ring_d.cnt = '0;
        end else if (push) begin
            ring_d.mem[ring_q.wp] = din;
            ring_d.wp = (ring_q.wp == IW'(DEPTH - 1)) ? '0 : ring_q.wp + 1'b1;
            if (!full) begin
                ring_d.cnt = ring_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_q <= '0;
        end else begin
            ring_q <= ring_d;
        end
    end

    assign rd_data = ring_q.mem[rd_idx];
    assign count   = ring_q.cnt;
    // Once full, the write pointer is also the slot of the longest-held byte.
    assign oldest  = full ? ring_q.wp : '0;

    // R3: a push into a full store keeps it full and moves the oldest slot along
    p_full_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !clr) |=> (count == CW'(DEPTH)) && (oldest != $past(oldest)));

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr && !full) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/pgb_commit.sv
// Drains the held bytes into the array, one programming slot per byte.
module pgb_commit #(
    parameter int AW       = 8,
    parameter int IW       = 4,
    parameter int CW       = 5,
    parameter int PROG_CYC = 4,
    localparam int TW      = $clog2(PROG_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [CW-1:0] n_bytes,
    input  logic [IW-1:0] first,
    input  logic [AW-1:0] base,
    output logic [IW-1:0] rd_idx,
    output logic          we,
    output logic [AW-1:0] addr,
    output logic          busy
);
    typedef struct packed {
        logic          busy;
        logic [CW-1:0] k;
        logic [TW-1:0] tmr;
        logic [CW-1:0] n;
        logic [IW-1:0] first;
        logic [AW-1:0] base;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (!seq_q.busy) begin
            if (go) begin
                seq_d.busy  = 1'b1;
                seq_d.k     = '0;
                seq_d.tmr   = '0;
                seq_d.n     = n_bytes;
                seq_d.first = first;
                seq_d.base  = base;
            end
        end else if (seq_q.tmr == TW'(PROG_CYC - 1)) begin
            seq_d.tmr = '0;
            if (seq_q.k == seq_q.n - 1'b1) begin
                seq_d.busy = 1'b0;
            end else begin
                seq_d.k = seq_q.k + 1'b1;
            end
        end else begin
            seq_d.tmr = seq_q.tmr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy   = seq_q.busy;
    assign we     = seq_q.busy && (seq_q.tmr == '0);
    assign rd_idx = seq_q.first + seq_q.k[IW-1:0];
    assign addr   = {seq_q.base[AW-1:IW], seq_q.base[IW-1:0] + seq_q.k[IW-1:0]};

    p_we_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> busy);

    p_first_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> we);

    p_go_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy);

    generate
        if (PROG_CYC > 1) begin : g_gap
            p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
                we |=> !we);
        end
    endgenerate
endmodule

// File: rtl/page_wbuf.sv
module page_wbuf
    import page_wbuf_pkg::*;
#(
    parameter int DW       = 8,
    parameter int AW       = 8,
    parameter int DEPTH    = 16,
    parameter int PROG_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          txn_start,
    input  logic          txn_stop,
    input  logic          byte_vld,
    input  logic [DW-1:0] byte_data,
    input  logic [AW-1:0] start_addr,
    input  logic          veto,
    output logic          busy,
    output logic          arr_we,
    output logic [AW-1:0] arr_addr,
    output logic [DW-1:0] arr_wdata
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        wb_mode_e      mode;
        logic [AW-1:0] base;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    logic          ring_clr, ring_push, go;
    logic [CW-1:0] held;
    logic [IW-1:0] oldest, rd_idx;

    always_comb begin
        ctl_d     = ctl_q;
        ring_clr  = 1'b0;
        ring_push = 1'b0;
        go        = 1'b0;
        unique case (ctl_q.mode)
            MODE_IDLE: begin
                if (txn_start && !busy) begin
                    ctl_d.mode = MODE_OPEN;
                    ctl_d.base = start_addr;
                    ring_clr   = 1'b1;
                end
            end
            MODE_OPEN: begin
                if (txn_start) begin
                    ctl_d.base = start_addr;
                    ring_clr   = 1'b1;
                end else if (txn_stop) begin
                    ctl_d.mode = MODE_IDLE;
                    go         = !veto && (held != '0);
                end else if (byte_vld) begin
                    ring_push  = 1'b1;
                end
            end
            default: ctl_d.mode = MODE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{mode: MODE_IDLE, base: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    pgb_ring #(.DW(DW), .DEPTH(DEPTH)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ring_clr),
        .push    (ring_push),
        .din     (byte_data),
        .rd_idx  (rd_idx),
        .rd_data (arr_wdata),
        .count   (held),
        .oldest  (oldest)
    );

    pgb_commit #(.AW(AW), .IW(IW), .CW(CW), .PROG_CYC(PROG_CYC)) u_commit (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .n_bytes (held),
        .first   (oldest),
        .base    (ctl_q.base),
        .rd_idx  (rd_idx),
        .we      (arr_we),
        .addr    (arr_addr),
        .busy    (busy)
    );

    p_no_write_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.mode == MODE_OPEN) |-> !arr_we);

    p_restart_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.mode == MODE_OPEN && txn_start) |=> (held == '0));

    p_veto_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.mode == MODE_OPEN && txn_stop && !txn_start && veto) |=> !busy);

    p_empty_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.mode == MODE_OPEN && txn_stop && !txn_start && held == '0) |=> !busy);

    p_idle_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.mode == MODE_IDLE && byte_vld && !txn_start) |=> $stable(held));

    p_stop_commits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.mode == MODE_OPEN && txn_stop && !txn_start && !veto && held != '0)
        |=> $rose(busy));
endmodule

// File: tb/sim_page_wbuf.sv
module sim_page_wbuf;
    localparam int PERIOD = 10;
    localparam int PCYC   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txn_start = 1'b0, txn_stop = 1'b0, byte_vld = 1'b0, veto = 1'b0;
    logic [7:0] byte_data = '0, start_addr = '0;
    logic       busy, arr_we;
    logic [7:0] arr_addr, arr_wdata;

    int checks = 0;
    int fails  = 0;

    logic [7:0] mem [256];
    logic [7:0] log_a [512];
    logic [7:0] log_d [512];
    int wr_n = 0;
    int busy_n = 0;

    always #(PERIOD/2) clk = ~clk;

    page_wbuf #(.PROG_CYC(PCYC)) u0 (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_stop(txn_stop),
        .byte_vld(byte_vld), .byte_data(byte_data), .start_addr(start_addr),
        .veto(veto), .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata)
    );

    // Array model and write log, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && arr_we) begin
            mem[arr_addr] = arr_wdata;
            if (wr_n < 512) begin
                log_a[wr_n] = arr_addr;
                log_d[wr_n] = arr_wdata;
            end
            wr_n = wr_n + 1;
        end
        if (rst_n && busy) busy_n = busy_n + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && busy; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Opens a transaction, sends n bytes d0, d0+1, ... and closes it.
    task automatic send(input logic [7:0] a, input int n, input logic [7:0] d0, input bit vt);
        txn_start = 1'b1; start_addr = a;
        @(negedge clk);
        txn_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_vld = 1'b1; byte_data = d0 + 8'(i);
            @(negedge clk);
        end
        byte_vld = 1'b0;
        txn_stop = 1'b1; veto = vt;
        @(negedge clk);
        txn_stop = 1'b0; veto = 1'b0;
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R11 busy after reset", busy, 0);
        chk(arr_we == 1'b0, "R11 we after reset", arr_we, 0);
    endtask

    task automatic t_basic();
        int w0 = wr_n; int b0 = busy_n;
        send(8'h20, 3, 8'h11, 1'b0);
        chk(busy == 1'b1, "R7 busy after stop", busy, 1);
        wait_idle();
        chk(wr_n - w0 == 3, "R2 write count", wr_n - w0, 3);
        chk(busy_n - b0 == 3 * PCYC, "R7 busy length", busy_n - b0, 3 * PCYC);
        for (int k = 0; k < 3; k++) begin
            chk(mem[8'h20 + k] == 8'h11 + k, "R2 data order", mem[8'h20 + k], 8'h11 + k);
        end
    endtask

    task automatic t_overflow();
        int w0 = wr_n;
        txn_start = 1'b1; start_addr = 8'h45;
        @(negedge clk);
        txn_start = 1'b0;
        for (int i = 0; i < 20; i++) begin
            byte_vld = 1'b1; byte_data = 8'hA0 + 8'(i);
            @(negedge clk);
        end
        byte_vld = 1'b0;
        chk(wr_n == w0, "R4 no write before stop", wr_n - w0, 0);
        txn_stop = 1'b1;
        @(negedge clk);
        txn_stop = 1'b0;
        wait_idle();
        chk(wr_n - w0 == 16, "R3 only 16 written", wr_n - w0, 16);
        for (int j = 0; j < 16; j++) begin
            logic [7:0] ea = {4'h4, 4'(5 + j)};
            chk(log_d[w0 + j] == 8'hA4 + 8'(j), "R3 oldest dropped", log_d[w0 + j], 8'hA4 + j);
            chk(log_a[w0 + j] == ea, "R6 page wrap address", log_a[w0 + j], ea);
        end
    endtask

    task automatic t_veto();
        int w0 = wr_n; int b0 = busy_n;
        send(8'h60, 5, 8'h33, 1'b1);
        wait_idle();
        chk(wr_n == w0, "R8 veto writes", wr_n - w0, 0);
        chk(busy_n == b0, "R8 veto busy", busy_n - b0, 0);
    endtask

    task automatic t_restart();
        int w0 = wr_n;
        txn_start = 1'b1; start_addr = 8'h70;
        @(negedge clk);
        txn_start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            byte_vld = 1'b1; byte_data = 8'h50 + 8'(i);
            @(negedge clk);
        end
        byte_vld = 1'b0;
        send(8'h8E, 3, 8'hC0, 1'b0);
        wait_idle();
        chk(wr_n - w0 == 3, "R5 restart count", wr_n - w0, 3);
        chk(mem[8'h70] == 8'h00, "R5 old bytes dropped", mem[8'h70], 0);
        chk(mem[8'h8E] == 8'hC0 && mem[8'h8F] == 8'hC1, "R6 new base", mem[8'h8F], 8'hC1);
        chk(mem[8'h80] == 8'hC2, "R6 wrap to page start", mem[8'h80], 8'hC2);
    endtask

    task automatic t_empty();
        int w0 = wr_n; int b0 = busy_n;
        send(8'hA0, 0, 8'h00, 1'b0);
        wait_idle();
        chk(wr_n == w0 && busy_n == b0, "R9 empty stop", wr_n - w0, 0);
    endtask

    task automatic t_idle_bytes();
        int w0 = wr_n;
        for (int i = 0; i < 4; i++) begin
            byte_vld = 1'b1; byte_data = 8'hE0 + 8'(i);
            @(negedge clk);
        end
        byte_vld = 1'b0;
        txn_stop = 1'b1;
        @(negedge clk);
        txn_stop = 1'b0;
        send(8'hB0, 1, 8'h77, 1'b0);
        wait_idle();
        chk(wr_n - w0 == 1, "R10 idle bytes ignored", wr_n - w0, 1);
        chk(mem[8'hB0] == 8'h77, "R10 data", mem[8'hB0], 8'h77);
    endtask

    task automatic t_start_busy();
        int w0 = wr_n;
        send(8'hC0, 2, 8'h21, 1'b0);
        txn_start = 1'b1; start_addr = 8'hD0;
        @(negedge clk);
        txn_start = 1'b0; byte_vld = 1'b1; byte_data = 8'h99;
        @(negedge clk);
        byte_vld = 1'b0; txn_stop = 1'b1;
        @(negedge clk);
        txn_stop = 1'b0;
        wait_idle();
        chk(wr_n - w0 == 2, "R1 start while busy", wr_n - w0, 2);
        chk(mem[8'hD0] == 8'h00, "R1 no write", mem[8'hD0], 0);
    endtask

    task automatic t_priority();
        int w0 = wr_n;
        txn_start = 1'b1; start_addr = 8'hE0;
        @(negedge clk);
        txn_start = 1'b0; byte_vld = 1'b1; byte_data = 8'h41;
        @(negedge clk);
        txn_stop = 1'b1; byte_data = 8'h42;
        @(negedge clk);
        txn_stop = 1'b0; byte_vld = 1'b0;
        wait_idle();
        chk(wr_n - w0 == 1, "R12 stop beats byte", wr_n - w0, 1);
        w0 = wr_n;
        txn_start = 1'b1; start_addr = 8'hF0;
        @(negedge clk);
        txn_start = 1'b0; byte_vld = 1'b1; byte_data = 8'h51;
        @(negedge clk);
        byte_vld = 1'b0; txn_start = 1'b1; txn_stop = 1'b1; start_addr = 8'hF8;
        @(negedge clk);
        txn_start = 1'b0; txn_stop = 1'b0;
        chk(busy == 1'b0 && wr_n == w0, "R12 start beats stop", wr_n - w0, 0);
        send(8'hF8, 0, 8'h00, 1'b0);
        wait_idle();
    endtask

    initial begin
        #(PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_overflow();
        t_veto();
        t_restart();
        t_empty();
        t_idle_bytes();
        t_start_busy();
        t_priority();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule